// File: doc/BRIEF.md
# Renaming Register File

This block keeps the architectural registers of an out-of-order core together with a rename alias for each one. The alias says whether the register's stored value is current or whether a reservation station still has to produce it. The issue stage looks up its source operands on the read ports. Each lookup returns either a usable value or the tag of the station to wait for. In the same cycle the issue stage claims the destination register for the station that receives the instruction.

When a functional unit finishes, it presents the producing station's tag and the result on the broadcast port. A register retires that result only if its alias still names that exact station. A register renamed again by a younger instruction keeps waiting for the younger producer. Lookups see the state held before the current cycle's rename. They also see a same-cycle broadcast through a bypass, so an operand that completes in the issue cycle is returned as ready.

Top module: `rat_regfile`

## Requirements
- R1: After reset every register reads as ready with value zero, with no alias pending.
- R2: A lookup of a register with no pending alias returns ready=1, the stored value on the value output and zero on the tag output.
- R3: A lookup of a register with a pending alias returns ready=0, the owning station tag on the tag output and zero on the value output.
- R4: A rename (rename valid high) sets the destination register's alias to the rename tag from the next cycle on, overwriting any earlier alias.
- R5: A valid broadcast whose tag equals a register's alias writes the broadcast value into that register and clears its alias from the next cycle on.
- R6: A register whose alias names another station, or which has no alias, keeps its value and alias through a broadcast.
- R7: A lookup in the cycle a rename is presented returns the state before that rename, so an instruction reading its own destination waits on the older producer or reads the old value.
- R8: When a rename and a matching broadcast hit the same register in one cycle, the alias takes the rename tag and is not cleared.
- R9: A lookup of a register whose alias equals the tag being validly broadcast in that cycle returns ready=1 with the broadcast value.
- R10: The read ports are independent: each returns the result for its own index in the same cycle.
- R11: A rename or broadcast presented with its valid input low changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_idx | input | NUM_RD x IDX_W | Register index for each read port |
| rd_ready | output | NUM_RD | Port result is a value (1) or a tag to wait for (0) |
| rd_value | output | NUM_RD x DATA_W | Operand value when ready, else zero |
| rd_tag | output | NUM_RD x TAG_W | Producing station tag when not ready, else zero |
| ren_valid | input | 1 | Rename request valid |
| ren_idx | input | IDX_W | Destination register being renamed |
| ren_tag | input | TAG_W | Station that now owns the destination |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | TAG_W | Tag of the station that produced the result |
| bc_value | input | DATA_W | Result value |

## Verification
On every cycle the assertions check each register's alias update after a rename, its retirement after a matching broadcast, that a foreign or absent broadcast leaves a waiting register untouched, and that a not-ready lookup always names the station its register is waiting on. Only the directed scenarios can show the orderings within a cycle: a lookup reading the state before its own instruction's rename, the bypass of a same-cycle broadcast, a rename winning over a colliding broadcast, and stale broadcasts arriving after a re-rename.

// File: rtl/rat_pkg.sv
// Package: default sizes shared by the renaming register file and its checker.
// Assumes one result broadcast and one rename per cycle.
package rat_pkg;
    localparam int RAT_DATA_W   = 32;
    localparam int RAT_NUM_REGS = 16;
    localparam int RAT_NUM_TAGS = 8;
    localparam int RAT_NUM_RD   = 2;
endpackage

// File: rtl/rat_entry.sv
// One architectural register with its rename alias.
// Assumes at most one rename and one broadcast per cycle; rename beats a
// colliding broadcast for the alias, while the value still takes the result.
module rat_entry #(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ren_hit,
    input  logic [TAG_W-1:0]  ren_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_value,
    output logic [DATA_W-1:0] value_o,
    output logic              busy_o,
    output logic [TAG_W-1:0]  tag_o
);
    logic bc_match;

    // Broadcast retires this register only if it still names the producer.
    always_comb begin
        bc_match = bc_valid && busy_o && (tag_o == bc_tag);
    end

    // Value and alias update; rename takes priority over clearing the alias.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_o <= '0;
            busy_o  <= 1'b0;
            tag_o   <= '0;
        end else begin
            if (bc_match) begin
                value_o <= bc_value;
            end
            if (ren_hit) begin
                busy_o <= 1'b1;
                tag_o  <= ren_tag;
            end else if (bc_match) begin
                busy_o <= 1'b0;
                tag_o  <= '0;
            end
        end
    end
endmodule

// File: rtl/rat_read_port.sv
// One lookup port: selects a register and returns its value or its alias tag.
// Assumes the broadcast inputs are those of the current cycle (bypass path).
module rat_read_port #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 16,
    parameter int TAG_W    = 3,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic [IDX_W-1:0]                 idx,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  reg_value,
    input  logic [NUM_REGS-1:0]              reg_busy,
    input  logic [NUM_REGS-1:0][TAG_W-1:0]   reg_tag,
    input  logic                             bc_valid,
    input  logic [TAG_W-1:0]                 bc_tag,
    input  logic [DATA_W-1:0]                bc_value,
    output logic                             ready,
    output logic [DATA_W-1:0]                value,
    output logic [TAG_W-1:0]                 tag
);
    logic              sel_busy;
    logic [TAG_W-1:0]  sel_tag;
    logic [DATA_W-1:0] sel_value;

    // Pick the addressed register.
    always_comb begin
        sel_busy  = reg_busy[idx];
        sel_tag   = reg_tag[idx];
        sel_value = reg_value[idx];
    end

    // Resolve to stored value, bypassed broadcast, or pending tag.
    always_comb begin
        if (!sel_busy) begin
            ready = 1'b1;
            value = sel_value;
            tag   = '0;
        end else if (bc_valid && (bc_tag == sel_tag)) begin
            ready = 1'b1;
            value = bc_value;
            tag   = '0;
        end else begin
            ready = 1'b0;
            value = '0;
            tag   = sel_tag;
        end
    end
endmodule

// File: rtl/rat_regfile.sv
// Renaming register file: architectural registers plus per-register alias,
// NUM_RD lookup ports, one rename port and one result broadcast port.
// Assumes lookups in a cycle see the state before that cycle's rename.
module rat_regfile
    import rat_pkg::*;
#(
    parameter int DATA_W   = RAT_DATA_W,
    parameter int NUM_REGS = RAT_NUM_REGS,
    parameter int NUM_TAGS = RAT_NUM_TAGS,
    parameter int NUM_RD   = RAT_NUM_RD,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int TAG_W   = $clog2(NUM_TAGS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_RD-1:0][IDX_W-1:0]   rd_idx,
    output logic [NUM_RD-1:0]              rd_ready,
    output logic [NUM_RD-1:0][DATA_W-1:0]  rd_value,
    output logic [NUM_RD-1:0][TAG_W-1:0]   rd_tag,
    input  logic                           ren_valid,
    input  logic [IDX_W-1:0]               ren_idx,
    input  logic [TAG_W-1:0]               ren_tag,
    input  logic                           bc_valid,
    input  logic [TAG_W-1:0]               bc_tag,
    input  logic [DATA_W-1:0]              bc_value
);
    logic [NUM_REGS-1:0][DATA_W-1:0] val_q;
    logic [NUM_REGS-1:0]             busy_q;
    logic [NUM_REGS-1:0][TAG_W-1:0]  tag_q;

    // Register storage, one entry per architectural register.
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        logic hit;
        always_comb hit = ren_valid && (ren_idx == IDX_W'(r));
        rat_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_entry (
            .clk      (clk),
            .rst_n    (rst_n),
            .ren_hit  (hit),
            .ren_tag  (ren_tag),
            .bc_valid (bc_valid),
            .bc_tag   (bc_tag),
            .bc_value (bc_value),
            .value_o  (val_q[r]),
            .busy_o   (busy_q[r]),
            .tag_o    (tag_q[r])
        );
    end

    // Lookup ports, each independent of the others.
    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        rat_read_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .TAG_W(TAG_W)) u_port (
            .idx       (rd_idx[p]),
            .reg_value (val_q),
            .reg_busy  (busy_q),
            .reg_tag   (tag_q),
            .bc_valid  (bc_valid),
            .bc_tag    (bc_tag),
            .bc_value  (bc_value),
            .ready     (rd_ready[p]),
            .value     (rd_value[p]),
            .tag       (rd_tag[p])
        );
    end
endmodule

// File: rtl/rat_regfile_chk.sv
// Checker for the renaming register file, bound to every instance.
// Assumes default sizes from the package, as the binding passes none.
module rat_regfile_chk
    import rat_pkg::*;
#(
    parameter int DATA_W   = RAT_DATA_W,
    parameter int NUM_REGS = RAT_NUM_REGS,
    parameter int NUM_TAGS = RAT_NUM_TAGS,
    parameter int NUM_RD   = RAT_NUM_RD,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int TAG_W   = $clog2(NUM_TAGS)
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [NUM_RD-1:0][IDX_W-1:0]    rd_idx,
    input logic [NUM_RD-1:0]               rd_ready,
    input logic [NUM_RD-1:0][TAG_W-1:0]    rd_tag,
    input logic                            ren_valid,
    input logic [IDX_W-1:0]                ren_idx,
    input logic [TAG_W-1:0]                ren_tag,
    input logic                            bc_valid,
    input logic [TAG_W-1:0]                bc_tag,
    input logic [DATA_W-1:0]               bc_value,
    input logic [NUM_REGS-1:0][DATA_W-1:0] val_q,
    input logic [NUM_REGS-1:0]             busy_q,
    input logic [NUM_REGS-1:0][TAG_W-1:0]  tag_q
);
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg_chk
        logic hit;
        logic match;
        always_comb begin
            hit   = ren_valid && (ren_idx == IDX_W'(r));
            match = bc_valid && busy_q[r] && (tag_q[r] == bc_tag);
        end

        // R4 R8
        rename_sets_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit |=> busy_q[r] && (tag_q[r] == $past(ren_tag)));

        // R5
        bcast_retires_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (match && !hit) |=> !busy_q[r] && (val_q[r] == $past(bc_value)));

        // R6 R11
        foreign_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (busy_q[r] && !match && !hit) |=> busy_q[r] && $stable(tag_q[r]) && $stable(val_q[r]));
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd_chk
        // R3
        notready_names_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_ready[p] |-> busy_q[rd_idx[p]] && (rd_tag[p] == tag_q[rd_idx[p]]));
    end
endmodule

bind rat_regfile rat_regfile_chk u_rat_regfile_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (rd_idx),
    .rd_ready  (rd_ready),
    .rd_tag    (rd_tag),
    .ren_valid (ren_valid),
    .ren_idx   (ren_idx),
    .ren_tag   (ren_tag),
    .bc_valid  (bc_valid),
    .bc_tag    (bc_tag),
    .bc_value  (bc_value),
    .val_q     (val_q),
    .busy_q    (busy_q),
    .tag_q     (tag_q)
);

// File: tb/rat_regfile_bench.sv
// Directed bench for the renaming register file, one task per scenario.
module rat_regfile_bench;
    import rat_pkg::*;
    localparam int DW = RAT_DATA_W;
    localparam int NR = RAT_NUM_REGS;
    localparam int NP = RAT_NUM_RD;
    localparam int IW = $clog2(NR);
    localparam int TW = $clog2(RAT_NUM_TAGS);

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [NP-1:0][IW-1:0]   rd_idx = '0;
    logic [NP-1:0]           rd_ready;
    logic [NP-1:0][DW-1:0]   rd_value;
    logic [NP-1:0][TW-1:0]   rd_tag;
    logic                    ren_valid = 1'b0;
    logic [IW-1:0]           ren_idx = '0;
    logic [TW-1:0]           ren_tag = '0;
    logic                    bc_valid = 1'b0;
    logic [TW-1:0]           bc_tag = '0;
    logic [DW-1:0]           bc_value = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    rat_regfile u_rat_regfile (
        .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_ready(rd_ready),
        .rd_value(rd_value), .rd_tag(rd_tag), .ren_valid(ren_valid),
        .ren_idx(ren_idx), .ren_tag(ren_tag), .bc_valid(bc_valid),
        .bc_tag(bc_tag), .bc_value(bc_value)
    );

    always #4 clk = ~clk;  // 125 MHz

    // Advance one edge, then drop the one-shot strobes.
    task automatic cyc();
        @(posedge clk);
        #2;
        ren_valid = 1'b0;
        bc_valid  = 1'b0;
    endtask

    // Look up one port and compare ready, value and tag.
    task automatic expect_rd(input int p, input int idx, input logic rdy,
                             input logic [DW-1:0] val, input logic [TW-1:0] tg,
                             input string req);
        rd_idx[p] = IW'(idx);
        #1;
        checks++;
        if (rd_ready[p] !== rdy || rd_value[p] !== val || rd_tag[p] !== tg) begin
            errors++;
            $display("FAIL %s: port %0d reg %0d actual ready=%0b value=%h tag=%0d expected ready=%0b value=%h tag=%0d",
                     req, p, idx, rd_ready[p], rd_value[p], rd_tag[p], rdy, val, tg);
        end
    endtask

    task automatic do_rename(input int idx, input int tg);
        ren_valid = 1'b1;
        ren_idx   = IW'(idx);
        ren_tag   = TW'(tg);
    endtask

    task automatic do_bcast(input int tg, input logic [DW-1:0] v);
        bc_valid = 1'b1;
        bc_tag   = TW'(tg);
        bc_value = v;
    endtask

    // Put a known value into a register through rename and broadcast.
    task automatic load(input int idx, input int tg, input logic [DW-1:0] v);
        do_rename(idx, tg);
        cyc();
        do_bcast(tg, v);
        cyc();
    endtask

    task automatic t_reset();
        for (int r = 0; r < NR; r++) begin
            expect_rd(0, r, 1'b1, '0, '0, "R1");
            expect_rd(1, r, 1'b1, '0, '0, "R1");
            cyc();
        end
    endtask

    task automatic t_rename_retire();
        load(3, 2, 32'h0000_1234);
        expect_rd(0, 3, 1'b1, 32'h0000_1234, '0, "R2 R5");
        do_rename(5, 6);
        cyc();
        expect_rd(0, 5, 1'b0, '0, 3'd6, "R3 R4");
        do_bcast(6, 32'h0000_00aa);
        expect_rd(1, 5, 1'b1, 32'h0000_00aa, '0, "R9");
        cyc();
        expect_rd(0, 5, 1'b1, 32'h0000_00aa, '0, "R5");
    endtask

    task automatic t_stale();
        do_rename(7, 1);
        cyc();
        do_rename(7, 4);
        cyc();
        expect_rd(0, 7, 1'b0, '0, 3'd4, "R4");
        do_bcast(1, 32'h0000_0055);
        cyc();
        expect_rd(0, 7, 1'b0, '0, 3'd4, "R6");
        do_bcast(2, 32'hdead_beef);
        cyc();
        expect_rd(1, 3, 1'b1, 32'h0000_1234, '0, "R6");
        do_bcast(4, 32'h0000_0066);
        cyc();
        expect_rd(0, 7, 1'b1, 32'h0000_0066, '0, "R5");
    endtask

    task automatic t_self_read();
        load(1, 0, 32'h0000_0010);
        do_rename(1, 3);
        expect_rd(0, 1, 1'b1, 32'h0000_0010, '0, "R7");
        cyc();
        expect_rd(0, 1, 1'b0, '0, 3'd3, "R4");
        do_rename(1, 5);
        expect_rd(1, 1, 1'b0, '0, 3'd3, "R7");
        cyc();
        expect_rd(1, 1, 1'b0, '0, 3'd5, "R7");
        do_bcast(5, 32'h0000_0011);
        cyc();
    endtask

    task automatic t_collide();
        do_rename(9, 2);
        cyc();
        do_rename(9, 7);
        do_bcast(2, 32'h0000_0001);
        cyc();
        expect_rd(0, 9, 1'b0, '0, 3'd7, "R8");
        do_bcast(7, 32'h0000_0077);
        cyc();
        expect_rd(0, 9, 1'b1, 32'h0000_0077, '0, "R8");
    endtask

    task automatic t_ports();
        do_rename(12, 6);
        cyc();
        rd_idx[0] = IW'(3);
        rd_idx[1] = IW'(12);
        #1;
        checks++;
        if (rd_ready !== 2'b01 || rd_value[0] !== 32'h0000_1234 || rd_tag[1] !== 3'd6) begin
            errors++;
            $display("FAIL R10: actual ready=%b v0=%h t1=%0d expected ready=01 v0=00001234 t1=6",
                     rd_ready, rd_value[0], rd_tag[1]);
        end
        bc_valid = 1'b0;
        bc_tag   = 3'd6;
        bc_value = 32'h0000_0999;
        expect_rd(1, 12, 1'b0, '0, 3'd6, "R11");
        cyc();
        expect_rd(1, 12, 1'b0, '0, 3'd6, "R11");
        ren_valid = 1'b0;
        ren_idx   = IW'(14);
        ren_tag   = 3'd2;
        cyc();
        expect_rd(0, 14, 1'b1, '0, '0, "R11");
        do_bcast(6, 32'h0000_0abc);
        cyc();
        expect_rd(1, 12, 1'b1, 32'h0000_0abc, '0, "R5");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        t_reset();
        t_rename_retire();
        t_stale();
        t_self_read();
        t_collide();
        t_ports();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule